// File: doc/BRIEF.md
# Wishbone Pattern ROM to GPIO Player

This block is a Wishbone classic bus master that plays a light pattern from a table of 32-bit words. It reads one table word from the pattern ROM. It then issues two single-byte writes to a GPIO peripheral. The top byte of the word goes to the GPIO output-value register. The byte below it goes to the GPIO pin-direction register. All three accesses share one master port, and they run strictly one after another.

After the second write, the block waits for a programmable number of idle cycles, so that each step of the pattern stays visible on the LEDs. It then moves on to the next table word. After the last entry it returns to the first and repeats indefinitely.

The bus is 32 bits wide and little-endian. A byte at byte address 0x9100_0001 therefore travels on lane 1 of word address 0x9100_0000.

Top module: `wb_pattern_player`

## Requirements
- R1: While `rst` is high at a rising edge, `wbCyc` and `wbStb` are low in the following cycle. The first read of table word 0 is presented in the first cycle after `rst` is sampled low.
- R2: A table read of word i drives `wbAdr` = ROM_BASE + 4*i (default ROM_BASE 0x0800_0000), `wbWe`=0, `wbSel`=4'b1111 and `wbDatOut`=0. The word on `wbDatIn` is captured in the cycle `wbAck` is sampled high.
- R3: The output-value write follows each read. It drives `wbAdr`=GPIO_BASE (default 0x9100_0000), `wbWe`=1 and `wbSel`=4'b0001. `wbDatOut[7:0]` carries bits [31:24] of the captured word, and all other bits are 0.
- R4: The direction write follows the output-value write. It drives `wbAdr`=GPIO_BASE, `wbWe`=1 and `wbSel`=4'b0010. `wbDatOut[15:8]` carries bits [23:16] of the captured word, and all other bits are 0.
- R5: Accesses run in the fixed order read, value write, direction write for each word, never overlapping. `wbCyc` equals `wbStb` at all times.
- R6: Once `wbStb` is high, `wbStb`, `wbAdr`, `wbDatOut`, `wbSel` and `wbWe` hold steady until the cycle in which `wbAck` is sampled high.
- R7: `wbStb` and `wbCyc` are low in the cycle after `wbAck` is sampled high.
- R8: The table index advances by one per word (NUM_WORDS entries, default 10). After the last index it returns to 0, so the read following word NUM_WORDS-1 targets ROM_BASE.
- R9: Between an ack and the next strobe, the block leaves exactly 1 idle cycle after a read or a value write. After a direction write it leaves exactly GAP_CYCLES+1 idle cycles (default GAP_CYCLES 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wbAdr | output | 32 | Byte address of the current access |
| wbDatOut | output | 32 | Write data |
| wbDatIn | input | 32 | Read data from the pattern ROM |
| wbWe | output | 1 | Write enable |
| wbSel | output | 4 | Byte-lane select |
| wbStb | output | 1 | Strobe |
| wbCyc | output | 1 | Bus cycle valid |
| wbAck | input | 1 | Slave acknowledge |

## Verification
There are two main ways the internal state can go wrong, and both show up at the ports.

- A wrong table index or a missed wrap changes `wbAdr` on the very next read strobe. The bench also sees it one or two accesses later as a wrong byte in the GPIO writes.
- A phase register that skips or repeats a step breaks the read, value, direction order on the next strobe.

A bad gap counter changes the number of idle cycles before the following read. The bench counts these idle cycles exactly. A lost capture register puts stale bytes on `wbDatOut` in the first write after the read. Random slave wait states show whether the bus signals hold still while the block waits for an ack.

// File: rtl/wbpp_pkg.sv
package wbpp_pkg;
  typedef enum logic [1:0] {
    PH_READ = 2'd0,
    PH_DATA = 2'd1,
    PH_DIR  = 2'd2,
    PH_GAP  = 2'd3
  } phase_e;

  typedef struct packed {
    phase_e phase;     // current step of the per-word sequence
    logic   busy;      // a bus access is on the wires
    logic   latchWord; // capture read data this cycle
    logic   startGap;  // direction write finishing, arm gap counter
    logic   nextWord;  // gap over, move to next table entry
  } ctrl_s;
endpackage

// File: rtl/wbpp_ctrl.sv
module wbpp_ctrl
  import wbpp_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  ack,
  input  logic  gapDone,
  output ctrl_s ctrl
);
  phase_e phaseQ;
  logic   busyQ;

  always_comb begin
    ctrl.phase     = phaseQ;
    ctrl.busy      = busyQ;
    ctrl.latchWord = busyQ && ack && (phaseQ == PH_READ);
    ctrl.startGap  = busyQ && ack && (phaseQ == PH_DIR);
    ctrl.nextWord  = (phaseQ == PH_GAP) && gapDone;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phaseQ <= PH_READ;
      busyQ  <= 1'b0;
    end else if (busyQ) begin
      if (ack) begin
        busyQ <= 1'b0;
        case (phaseQ)
          PH_READ: phaseQ <= PH_DATA;
          PH_DATA: phaseQ <= PH_DIR;
          default: phaseQ <= PH_GAP;
        endcase
      end
    end else if (phaseQ == PH_GAP) begin
      if (gapDone) phaseQ <= PH_READ;
    end else begin
      busyQ <= 1'b1;
    end
  end

  // R7: access released in the cycle after it is acknowledged
  a_r7_release: assert property (@(posedge clk) disable iff (rst)
    busyQ && ack |=> !busyQ);

  // R5: no access is started while the gap is running
  a_r5_gap_quiet: assert property (@(posedge clk) disable iff (rst)
    (phaseQ == PH_GAP) && !gapDone |=> !busyQ);
endmodule

// File: rtl/wbpp_datapath.sv
module wbpp_datapath
  import wbpp_pkg::*;
#(
  parameter int unsigned NUM_WORDS  = 10,
  parameter int unsigned GAP_CYCLES = 4,
  parameter logic [31:0] ROM_BASE   = 32'h0800_0000,
  parameter logic [31:0] GPIO_BASE  = 32'h9100_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  ctrl_s       ctrl,
  input  logic [31:0] datIn,
  output logic [31:0] adr,
  output logic [31:0] datOut,
  output logic [3:0]  sel,
  output logic        we,
  output logic        gapDone
);
  localparam int unsigned IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int unsigned GAP_W = $clog2(GAP_CYCLES + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYCLES - 1);

  logic [IDX_W-1:0] idxQ;
  logic [31:0]      wordQ;
  logic [GAP_W-1:0] gapQ;
  logic [31:0]      romAdr;

  always_ff @(posedge clk) begin
    if (rst) begin
      idxQ <= '0;
    end else if (ctrl.nextWord) begin
      idxQ <= (idxQ == LAST_IDX) ? '0 : idxQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wordQ <= '0;
    end else if (ctrl.latchWord) begin
      wordQ <= datIn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ctrl.startGap) begin
      gapQ <= '0;
    end else if (ctrl.phase == PH_GAP && !gapDone) begin
      gapQ <= gapQ + 1'b1;
    end
  end

  assign gapDone = (gapQ == GAP_LAST);
  assign romAdr  = ROM_BASE + {{(30-IDX_W){1'b0}}, idxQ, 2'b00};

  always_comb begin
    adr    = romAdr;
    datOut = '0;
    sel    = 4'b1111;
    we     = 1'b0;
    case (ctrl.phase)
      PH_DATA: begin
        adr    = GPIO_BASE;
        datOut = {24'h0, wordQ[31:24]};
        sel    = 4'b0001;
        we     = 1'b1;
      end
      PH_DIR: begin
        adr    = GPIO_BASE;
        datOut = {16'h0, wordQ[23:16], 8'h0};
        sel    = 4'b0010;
        we     = 1'b1;
      end
      default: ;
    endcase
  end

  // R8: index stays inside the table
  a_r8_idx_range: assert property (@(posedge clk) disable iff (rst)
    idxQ <= LAST_IDX);

  // R8: stepping past the last entry lands on entry 0
  a_r8_wrap: assert property (@(posedge clk) disable iff (rst)
    ctrl.nextWord && (idxQ == LAST_IDX) |=> idxQ == '0);

  // R9: gap counter never runs beyond its programmed length
  a_r9_gap_bound: assert property (@(posedge clk) disable iff (rst)
    (ctrl.phase == PH_GAP) |-> gapQ <= GAP_LAST);
endmodule

// File: rtl/wb_pattern_player.sv
module wb_pattern_player
  import wbpp_pkg::*;
#(
  parameter int unsigned NUM_WORDS  = 10,
  parameter int unsigned GAP_CYCLES = 4,
  parameter logic [31:0] ROM_BASE   = 32'h0800_0000,
  parameter logic [31:0] GPIO_BASE  = 32'h9100_0000
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] wbAdr,
  output logic [31:0] wbDatOut,
  input  logic [31:0] wbDatIn,
  output logic        wbWe,
  output logic [3:0]  wbSel,
  output logic        wbStb,
  output logic        wbCyc,
  input  logic        wbAck
);
  ctrl_s ctrl;
  logic  gapDone;

  wbpp_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .ack     (wbAck),
    .gapDone (gapDone),
    .ctrl    (ctrl)
  );

  wbpp_datapath #(
    .NUM_WORDS  (NUM_WORDS),
    .GAP_CYCLES (GAP_CYCLES),
    .ROM_BASE   (ROM_BASE),
    .GPIO_BASE  (GPIO_BASE)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrl),
    .datIn   (wbDatIn),
    .adr     (wbAdr),
    .datOut  (wbDatOut),
    .sel     (wbSel),
    .we      (wbWe),
    .gapDone (gapDone)
  );

  assign wbStb = ctrl.busy;
  assign wbCyc = ctrl.busy;

  // R6: request held steady until acknowledged
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    wbStb && !wbAck |=> wbStb && $stable(wbAdr) && $stable(wbDatOut)
                        && $stable(wbSel) && $stable(wbWe));

  // R7: strobe drops after the ack
  a_r7_stb_drop: assert property (@(posedge clk) disable iff (rst)
    wbStb && wbAck |=> !wbStb && !wbCyc);

  // R3 / R4: GPIO writes touch exactly one byte lane
  a_r3_one_lane: assert property (@(posedge clk) disable iff (rst)
    wbStb && wbWe |-> $countones(wbSel) == 1 && wbAdr == GPIO_BASE);

  // R2: table reads use the full word
  a_r2_full_read: assert property (@(posedge clk) disable iff (rst)
    wbStb && !wbWe |-> wbSel == 4'b1111);
endmodule

// File: tb/wb_pattern_player_tb.sv
module wb_pattern_player_tb;
  localparam int unsigned NW   = 10;
  localparam int unsigned GAP  = 4;
  localparam logic [31:0] ROMB = 32'h0800_0000;
  localparam logic [31:0] GPB  = 32'h9100_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] wbAdr, wbDatOut;
  logic [31:0] wbDatIn = '0;
  logic        wbWe, wbStb, wbCyc;
  logic [3:0]  wbSel;
  logic        wbAck = 1'b0;

  int unsigned checks = 0, errors = 0, txn = 0, idle = 0, waitLeft = 0;
  bit          zeroWait = 1'b1, prevStb = 1'b0, prevAck = 1'b0, finished = 1'b0;
  logic [31:0] tbl [NW];
  logic [31:0] sAdr, sDat;
  logic [3:0]  sSel;
  logic        sWe;

  always #4 clk = ~clk;  // 125 MHz

  wb_pattern_player #(.NUM_WORDS(NW), .GAP_CYCLES(GAP), .ROM_BASE(ROMB), .GPIO_BASE(GPB)) u_dut (
    .clk(clk), .rst(rst), .wbAdr(wbAdr), .wbDatOut(wbDatOut), .wbDatIn(wbDatIn),
    .wbWe(wbWe), .wbSel(wbSel), .wbStb(wbStb), .wbCyc(wbCyc), .wbAck(wbAck)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int unsigned wordOf(input int unsigned n);
    return (n / 3) % NW;
  endfunction

  function automatic logic [31:0] expAdr(input int unsigned n);
    return (n % 3 == 0) ? ROMB + 32'(4 * wordOf(n)) : GPB;
  endfunction

  function automatic logic [3:0] expSel(input int unsigned n);
    return (n % 3 == 0) ? 4'b1111 : ((n % 3 == 1) ? 4'b0001 : 4'b0010);
  endfunction

  function automatic logic [31:0] expDat(input int unsigned n);
    logic [31:0] w;
    w = tbl[wordOf(n)];
    if (n % 3 == 1) return {24'h0, w[31:24]};
    if (n % 3 == 2) return {16'h0, w[23:16], 8'h0};
    return 32'h0;
  endfunction

  function automatic string tagOf(input int unsigned n);
    if (n >= 3 * NW) return "R8 wrapped";
    if (n % 3 == 0) return "R2 read";
    if (n % 3 == 1) return "R3 value write";
    return "R4 direction write";
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // bus monitor and slave models, all at the falling edge
  always @(negedge clk) begin
    if (rst) begin
      chk(!wbStb && !wbCyc, "R1 strobes low in reset", {30'h0, wbCyc, wbStb}, 32'h0);
      txn = 0; idle = 0; prevStb = 1'b0; prevAck = 1'b0; wbAck = 1'b0;
    end else begin
      if (prevAck) chk(!wbStb, "R7 strobe drop after ack", {31'h0, wbStb}, 32'h0);
      if (wbStb) begin
        chk(wbCyc == 1'b1, "R5 cyc with stb", {31'h0, wbCyc}, 32'h1);
        if (!prevStb) begin
          automatic int unsigned ei = (txn == 0) ? 0 : (((txn - 1) % 3 == 2) ? GAP + 1 : 1);
          chk(idle == ei, (txn == 0) ? "R1 first read timing" : "R9 idle cycles", idle, ei);
          waitLeft = zeroWait ? 0 : $urandom_range(0, 3);
          idle = 0;
        end else begin
          chk(wbAdr == sAdr && wbDatOut == sDat && wbSel == sSel && wbWe == sWe,
              "R6 held while waiting", wbAdr, sAdr);
        end
        chk(wbAdr == expAdr(txn), {tagOf(txn), " adr R5"}, wbAdr, expAdr(txn));
        chk(wbWe == (txn % 3 != 0), {tagOf(txn), " we"}, {31'h0, wbWe}, {31'h0, txn % 3 != 0});
        chk(wbSel == expSel(txn), {tagOf(txn), " sel"}, {28'h0, wbSel}, {28'h0, expSel(txn)});
        chk(wbDatOut == expDat(txn), {tagOf(txn), " data"}, wbDatOut, expDat(txn));
        sAdr = wbAdr; sDat = wbDatOut; sSel = wbSel; sWe = wbWe;
        if (!wbWe && wbAdr >= ROMB && ((wbAdr - ROMB) >> 2) < NW)
          wbDatIn = tbl[(wbAdr - ROMB) >> 2];
        else
          wbDatIn = $urandom;
        if (waitLeft == 0) begin
          wbAck = 1'b1;
          txn++;
        end else begin
          wbAck = 1'b0;
          waitLeft--;
        end
      end else begin
        idle++;
        wbAck = 1'b0;
        wbDatIn = $urandom;
      end
      prevStb = wbStb;
      prevAck = wbAck;
    end
  end

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", txn, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NW; i++) tbl[i] = $urandom;
    tbl[0] = 32'hFF00_1234;  // directed corner: all-ones value byte
    tbl[NW-1] = 32'h00FF_ABCD;  // directed corner: all-ones direction byte
    repeat (3) @(negedge clk);
    #2 rst = 1'b0;
    while (txn < 3 * NW + 6) @(negedge clk);  // zero-wait pass incl. wrap
    zeroWait = 1'b0;
    while (txn < 75) @(negedge clk);          // random wait states
    @(negedge clk);
    #2 rst = 1'b1;                            // mid-run reset
    repeat (3) @(negedge clk);
    #2 rst = 1'b0;
    while (txn < 36) @(negedge clk);          // restart from word 0, wrap again
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule